// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This controller runs a 12-bit successive-approximation converter through a bank of eight analog inputs with no processor involvement once a scan is started. It walks the enabled channels from the lowest index upward. For each channel it sets the input multiplexer and allows one cycle for the input to settle. It then requests a conversion and waits for the converter's done strobe. Channels whose enable bit is clear cost no cycles at all.

Each channel can be sampled a power-of-two number of times, from 1 to 16. The samples are summed in a single 16-bit accumulator, and the shifted mean is written into that channel's result register. When the last enabled channel is written, a sticky scan-complete flag is raised. In continuous mode the sequencer then starts over from the lowest enabled channel; otherwise it returns to idle. The enable mask and the averaging setting are captured when each scan begins.

Top module: `adc_scan_seq`

## Requirements
- R1: During a scan, conversions are requested only for channels whose bit is set in the enable mask (bit i = channel i). Channels are visited in ascending index order, each once per scan, and `mux_sel` holds the channel index while its conversions run.
- R2: `mux_sel` holds its value for at least one full cycle before each `conv_start` pulse. `conv_start` is high for one cycle only, and no further pulse is issued until `conv_done` has been seen.
- R3: Each enabled channel is converted 2^A times, where A is `cfg_avg_log2` with values above 4 treated as 4. The stored result is floor(sum of the samples / 2^A), and the 16-bit sum never overflows.
- R4: `res_flat[12*i+11:12*i]` holds the result of channel i. A channel that is disabled during a scan keeps its earlier value.
- R5: `done_flag` rises at the end of a scan and stays high until the next accepted start. An accepted start clears it at the same clock edge.
- R6: At the end of a scan, if `cfg_continuous` is 1, a new scan begins at the lowest enabled channel using the mask present at that moment. If `cfg_continuous` is 0, `busy` drops to 0.
- R7: A start with an all-zero mask sets `done_flag` at that clock edge. No conversion is requested and `busy` stays 0.
- R8: A `cfg_start` pulse while `busy` is 1 is ignored.
- R9: After reset, `busy`, `done_flag`, `conv_start` and `mux_sel` are 0, and every result register is 0.
- R10: Changes to the enable mask or the averaging setting during a scan do not affect that scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ch_en | input | 8 | Channel enable mask, bit i enables channel i |
| cfg_avg_log2 | input | 3 | log2 of the samples per channel (values above 4 are clamped to 4) |
| cfg_start | input | 1 | Start request, taken only when idle |
| cfg_continuous | input | 1 | Restart automatically at the end of each scan |
| mux_sel | output | 3 | Analog multiplexer channel select |
| conv_start | output | 1 | One-cycle conversion request |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | 12 | Conversion result, valid with `conv_done` |
| res_flat | output | 96 | Eight 12-bit per-channel results, channel 0 in the low bits |
| done_flag | output | 1 | Sticky scan-complete flag |
| busy | output | 1 | A scan is in progress |

## Verification
The assertions rely on the converter raising `conv_done` for exactly one cycle, and only while a request is outstanding. They also rely on `conv_data` staying within 12 bits, which is what makes the no-overflow property depend on the sample count alone. The bench's behavioural converter honours both: it answers each pulse once, after a fixed latency, and never strobes on its own. The bench also changes configuration inputs only between clock edges, and its mid-scan changes are timed to land while a request is outstanding.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SETTLE = 2'd1,
        S_START  = 2'd2,
        S_WAIT   = 2'd3
    } scan_state_e;
endpackage

// File: rtl/adc_scan_pick.sv
module adc_scan_pick #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [CH_W:0]     lo,
    output logic              found,
    output logic [CH_W-1:0]   idx
);
    // Lowest set mask bit at or above index lo.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i] && ((CH_W+1)'(i) >= lo)) begin
                found = 1'b1;
                idx   = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/adc_scan_results.sv
module adc_scan_results #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 12,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_CH*DATA_W-1:0] res_flat
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q <= '0;
            else if (wr_en && (wr_idx == CH_W'(g)))
                slot_q <= wr_data;
        end
        assign res_flat[g*DATA_W +: DATA_W] = slot_q;
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int DATA_W   = 12,
    parameter int ACC_W    = 16,
    parameter int MAX_LOG2 = 4,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int AVG_W   = $clog2(MAX_LOG2 + 1),
    localparam int CNT_W   = (MAX_LOG2 < 1) ? 1 : MAX_LOG2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        cfg_ch_en,
    input  logic [AVG_W-1:0]         cfg_avg_log2,
    input  logic                     cfg_start,
    input  logic                     cfg_continuous,
    output logic [CH_W-1:0]          mux_sel,
    output logic                     conv_start,
    input  logic                     conv_done,
    input  logic [DATA_W-1:0]        conv_data,
    output logic [NUM_CH*DATA_W-1:0] res_flat,
    output logic                     done_flag,
    output logic                     busy
);
    typedef struct packed {
        scan_state_e       st;
        logic [CH_W-1:0]   ch;
        logic [NUM_CH-1:0] en;
        logic [AVG_W-1:0]  avg;
        logic [CNT_W-1:0]  cnt;
        logic [ACC_W-1:0]  acc;
        logic              done;
    } seq_t;

    seq_t s_q, s_d;

    logic              first_found, next_found;
    logic [CH_W-1:0]   first_idx, next_idx;
    logic [AVG_W-1:0]  avg_eff;
    logic [ACC_W:0]    sum_wide;
    logic [ACC_W-1:0]  sum, mean;
    logic              last_sample;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;

    adc_scan_pick #(.NUM_CH(NUM_CH)) u_first (
        .mask (cfg_ch_en),
        .lo   ('0),
        .found(first_found),
        .idx  (first_idx)
    );

    adc_scan_pick #(.NUM_CH(NUM_CH)) u_next (
        .mask (s_q.en),
        .lo   ({1'b0, s_q.ch} + (CH_W+1)'(1)),
        .found(next_found),
        .idx  (next_idx)
    );

    adc_scan_results #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (s_q.ch),
        .wr_data (wr_data),
        .res_flat(res_flat)
    );

    assign avg_eff     = (cfg_avg_log2 > AVG_W'(MAX_LOG2)) ? AVG_W'(MAX_LOG2) : cfg_avg_log2;
    assign sum_wide    = {1'b0, s_q.acc} + (ACC_W+1)'(conv_data);
    assign sum         = sum_wide[ACC_W-1:0];
    assign mean        = sum >> s_q.avg;
    assign last_sample = (s_q.cnt == CNT_W'((32'd1 << s_q.avg) - 32'd1));

    always_comb begin
        s_d     = s_q;
        wr_en   = 1'b0;
        wr_data = mean[DATA_W-1:0];
        unique case (s_q.st)
            S_IDLE: begin
                if (cfg_start) begin
                    if (first_found) begin
                        s_d.done = 1'b0;
                        s_d.st   = S_SETTLE;
                        s_d.ch   = first_idx;
                        s_d.en   = cfg_ch_en;
                        s_d.avg  = avg_eff;
                        s_d.cnt  = '0;
                        s_d.acc  = '0;
                    end else begin
                        s_d.done = 1'b1;
                    end
                end
            end
            S_SETTLE: s_d.st = S_START;
            S_START:  s_d.st = S_WAIT;
            S_WAIT: begin
                if (conv_done) begin
                    if (!last_sample) begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                        s_d.acc = sum;
                        s_d.st  = S_START;
                    end else begin
                        wr_en   = 1'b1;
                        s_d.cnt = '0;
                        s_d.acc = '0;
                        if (next_found) begin
                            s_d.ch = next_idx;
                            s_d.st = S_SETTLE;
                        end else begin
                            s_d.done = 1'b1;
                            if (cfg_continuous && first_found) begin
                                s_d.st  = S_SETTLE;
                                s_d.ch  = first_idx;
                                s_d.en  = cfg_ch_en;
                                s_d.avg = avg_eff;
                            end else begin
                                s_d.st = S_IDLE;
                            end
                        end
                    end
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: S_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mux_sel    = s_q.ch;
    assign conv_start = (s_q.st == S_START);
    assign done_flag  = s_q.done;
    assign busy       = (s_q.st != S_IDLE);

    // Mux must have been steady for the cycle before each request (R2)
    assert_settle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $stable(mux_sel));

    // Single-cycle request pulse (R2)
    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // Requests only for channels captured as enabled (R1)
    assert_mux_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> s_q.en[mux_sel]);

    // The search for the next channel only moves upward to an enabled bit (R1)
    assert_next_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
        next_found |-> (s_q.en[next_idx] && (next_idx > s_q.ch)));

    // Accumulator never carries out (R3)
    assert_acc_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_WAIT && conv_done) |-> !sum_wide[ACC_W]);

    // Completion flag is sticky until an accepted start (R5)
    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !(cfg_start && !busy)) |=> done_flag);

    // Empty mask completes immediately without a scan (R7)
    assert_zero_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_start && (cfg_ch_en == '0)) |=> (done_flag && !busy));
endmodule

// File: tb/adc_scan_seq_bench.sv
`timescale 1ns/1ps
module adc_scan_seq_bench;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_ch_en = '0;
    logic [2:0]  cfg_avg_log2 = '0;
    logic        cfg_start = 1'b0;
    logic        cfg_continuous = 1'b0;
    logic [2:0]  mux_sel;
    logic        conv_start;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic [95:0] res_flat;
    logic        done_flag;
    logic        busy;

    int n_checks = 0;
    int n_fail   = 0;
    int log_ch[$];
    int log_val[$];
    int n_conv = 0;
    int exp_res[8];
    int settle_err = 0;
    int pulse_err = 0;
    logic [2:0] prev_mux = '0;
    logic prev_start = 1'b0;

    always #2 clk = ~clk;

    adc_scan_seq u_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .cfg_ch_en(cfg_ch_en), .cfg_avg_log2(cfg_avg_log2),
        .cfg_start(cfg_start), .cfg_continuous(cfg_continuous), .mux_sel(mux_sel),
        .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
        .res_flat(res_flat), .done_flag(done_flag), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Behavioural converter: answers each request once after LAT cycles
    initial begin
        forever begin
            @(posedge clk); #1;
            while (conv_start) begin
                int v;
                v = (int'(mux_sel) * 509 + n_conv * 211 + 77) % 4096;
                n_conv++;
                log_ch.push_back(int'(mux_sel));
                log_val.push_back(v);
                repeat (LAT) @(posedge clk);
                #1;
                conv_done = 1'b1;
                conv_data = 12'(v);
                @(posedge clk); #1;
                conv_done = 1'b0;
            end
        end
    end

    // Monitor for mux settling and pulse width (R2)
    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_start && (mux_sel != prev_mux)) settle_err++;
            if (conv_start && prev_start) pulse_err++;
        end
        prev_mux   <= mux_sel;
        prev_start <= conv_start;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_up();
    end

    task automatic do_start();
        @(posedge clk); #1;
        cfg_start = 1'b1;
        @(posedge clk); #1;
        cfg_start = 1'b0;
    endtask

    task automatic wait_idle_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk); #1;
            if (done_flag && !busy) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic check_scan(input logic [7:0] mask, input int a, input int from);
        int idx;
        int cnt;
        idx = from;
        cnt = 1 << a;
        for (int ch = 0; ch < 8; ch++) begin
            if (mask[ch]) begin
                int sum;
                sum = 0;
                for (int k = 0; k < cnt; k++) begin
                    if (idx < log_ch.size()) begin
                        chk(log_ch[idx] == ch, "R1", log_ch[idx], ch);
                        sum += log_val[idx];
                    end
                    idx++;
                end
                exp_res[ch] = sum >> a;
            end
        end
        chk(log_ch.size() == idx, "R3", log_ch.size(), idx);
    endtask

    task automatic check_results(input string req);
        for (int ch = 0; ch < 8; ch++)
            chk(int'(res_flat[ch*12 +: 12]) == exp_res[ch], req,
                int'(res_flat[ch*12 +: 12]), exp_res[ch]);
    endtask

    task automatic run_scan(input logic [7:0] mask, input int avg);
        bit ok;
        int a;
        a = (avg > 4) ? 4 : avg;
        cfg_ch_en = mask;
        cfg_avg_log2 = 3'(avg);
        log_ch.delete();
        log_val.delete();
        do_start();
        if (mask == 8'h00) begin
            chk(done_flag == 1'b1, "R7", done_flag, 1);
            chk(busy == 1'b0, "R7", busy, 0);
            repeat (6) @(posedge clk);
            #1;
            chk(log_ch.size() == 0, "R7", log_ch.size(), 0);
        end else begin
            chk(done_flag == 1'b0, "R5", done_flag, 0);
            chk(busy == 1'b1, "R5", busy, 1);
            wait_idle_done(ok);
            chk(ok, "R5", ok, 1);
            check_scan(mask, a, 0);
            check_results("R4");
        end
    endtask

    initial begin
        bit ok;
        for (int i = 0; i < 8; i++) exp_res[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        chk(busy == 1'b0, "R9", busy, 0);
        chk(done_flag == 1'b0, "R9", done_flag, 0);
        chk(conv_start == 1'b0, "R9", conv_start, 0);
        chk(mux_sel == 3'd0, "R9", mux_sel, 0);
        chk(res_flat == '0, "R9", 1, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1, R4, R5, R7: every mask, one sample each
        for (int m = 0; m < 256; m++) run_scan(8'(m), 0);

        // R3: averaging depths including clamped settings
        for (int p = 0; p < 5; p++) begin
            logic [7:0] msk;
            case (p)
                0: msk = 8'hFF;
                1: msk = 8'h81;
                2: msk = 8'h5A;
                3: msk = 8'h10;
                default: msk = 8'hC3;
            endcase
            for (int av = 0; av < 8; av++) run_scan(msk, av);
        end

        // R8, R10: start and config changes during a scan are ignored
        cfg_ch_en = 8'h0F;
        cfg_avg_log2 = 3'd0;
        log_ch.delete();
        log_val.delete();
        do_start();
        repeat (3) @(posedge clk);
        #1;
        cfg_ch_en = 8'hF0;
        cfg_avg_log2 = 3'd2;
        cfg_start = 1'b1;
        @(posedge clk); #1;
        cfg_start = 1'b0;
        chk(done_flag == 1'b0, "R8", done_flag, 0);
        wait_idle_done(ok);
        chk(ok, "R8", ok, 1);
        check_scan(8'h0F, 0, 0);
        chk(log_ch.size() == 4, "R10", log_ch.size(), 4);
        check_results("R10");

        // R6: continuous mode restarts at the lowest enabled channel
        cfg_ch_en = 8'h24;
        cfg_avg_log2 = 3'd1;
        cfg_continuous = 1'b1;
        log_ch.delete();
        log_val.delete();
        do_start();
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            if (log_ch.size() >= 6) break;
        end
        chk(done_flag == 1'b1, "R6", done_flag, 1);
        chk(busy == 1'b1, "R6", busy, 1);
        cfg_continuous = 1'b0;
        wait_idle_done(ok);
        chk(ok, "R6", ok, 1);
        chk(log_ch.size() % 4 == 0 && log_ch.size() >= 8, "R6", log_ch.size(), 8);
        for (int i = 0; i < log_ch.size(); i++)
            chk(log_ch[i] == (((i % 4) < 2) ? 2 : 5), "R6", log_ch[i], ((i % 4) < 2) ? 2 : 5);
        check_scan(8'h24, 1, log_ch.size() - 4);
        check_results("R6");

        // R2: settle and pulse monitor totals
        chk(settle_err == 0, "R2", settle_err, 0);
        chk(pulse_err == 0, "R2", pulse_err, 0);
        finish_up();
    end
endmodule